// File: doc/BRIEF.md
# Frame Start and Byte Strobe Detector

This block sits behind a line decoder that has already turned the received signal into NRZ bits and has recovered their clock. That clock runs only while a frame is on the wire and stops between frames. The detector follows the alternating one/zero preamble and locks onto the pair of consecutive ones that closes the start delimiter `1,0,1,0,1,0,1,1`. At that point it raises a delimiter mark. For the rest of the frame the same mark pulses at every byte boundary. Alongside the mark it delivers each assembled byte, a one-cycle byte-valid pulse and the byte's position in the frame, so that downstream matching logic can examine any field of the frame and is not limited to the destination address.

Carrier sense bounds a frame. When it is sampled low, the detector returns to hunting for the next preamble and drops any partly assembled byte. A preamble timeout also returns the preamble tracker to its starting point. The byte output cannot be stalled, because the bit stream arrives at line rate and the decoder cannot pause it. There is therefore no ready input. A consumer must accept the byte on every cycle in which `byte_valid` is high, and it has eight receive-clock cycles to do so before the next byte replaces it.

Top module: `sfd_byte_strobe`

## Requirements
- R1: After reset, `delim_mark`, `byte_valid` and `frame_active` are low, and `byte_data` and `byte_idx` are zero.
- R2: A pair of consecutive ones with at least two alternating bits in front of it is taken as the start delimiter. On the clock edge that samples the second one, `delim_mark` and `frame_active` go high. `delim_mark` stays high for exactly one cycle.
- R3: A pair of ones with fewer than two alternating bits in front of it is ignored. No mark is raised, `frame_active` stays low, and the second one of the pair counts as the first bit of a new alternating run.
- R4: After the delimiter, bits are packed least-significant bit first. On the edge that samples the eighth bit of a byte, `byte_data` takes the byte and `byte_valid` is high for that one cycle only. `byte_valid` is never high outside a frame.
- R5: `delim_mark` is high in the same cycle as every `byte_valid` pulse, which marks each byte boundary.
- R6: `byte_idx` is 0 for the first byte after the delimiter and goes up by one for each later byte. It saturates at 255.
- R7: A clock edge that samples `crs` low clears `frame_active`, suppresses `byte_valid`, and discards any partial byte. After the next delimiter, the first byte is assembled only from new bits and has index 0.
- R8: If `PRE_LIMIT` bits are sampled during the hunt without a delimiter, the last of those bits is dropped and the alternating run restarts from zero. A pair of ones that follows at once is then ignored, as described in R3.
- R9: `byte_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive clock; toggles only during frames |
| rst_n | input | 1 | Asynchronous active-low reset |
| crs | input | 1 | Carrier sense; low ends the frame |
| rxd | input | 1 | NRZ receive data, sampled on rising `rx_clk` |
| delim_mark | output | 1 | Pulse at delimiter detection and at each byte boundary |
| byte_valid | output | 1 | One-cycle pulse when `byte_data` holds a new byte |
| byte_data | output | 8 | Assembled byte, LSB received first |
| byte_idx | output | 8 | Position of the byte after the delimiter, saturating at 255 |
| frame_active | output | 1 | High from delimiter detection until carrier drops |

## Verification
The bench sends pairs of ones that arrive too early, both right after a carrier drop and right after a preamble timeout. A detector that counted the first one of the pair as preamble would lock on these pairs and frame every later byte at the wrong offset. It also drops carrier in the middle of a byte and then restarts a frame. A design that kept the leftover bits would report a corrupted first byte or a nonzero index. The bench runs the byte count past 255 to catch a counter that wraps instead of saturating. It also checks bit order and mark timing on known byte values, so a bit assembly that is off by one position shows up as a wrong byte.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } hunt_state_e;
endpackage

// File: rtl/sfd_hunter.sv
module sfd_hunter
  import sfd_pkg::*;
#(
  parameter int MIN_ALT   = 2,
  parameter int PRE_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crs,
  input  logic rxd,
  output logic sfd_hit,
  output logic locked
);
  localparam int RUN_MAX = MIN_ALT + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int CNT_W   = $clog2(PRE_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PRE_LIMIT - 1);

  hunt_state_e      state;
  logic             prev;
  logic [RUN_W-1:0] run;
  logic [CNT_W-1:0] hcnt;
  logic             pair;

  assign pair    = (run != '0) && rxd && prev;
  assign sfd_hit = crs && (state == ST_HUNT) && pair && (run >= RUN_TOP);
  assign locked  = (state == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      prev  <= 1'b0;
      run   <= '0;
      hcnt  <= '0;
    end else if (!crs) begin
      state <= ST_HUNT;
      prev  <= 1'b0;
      run   <= '0;
      hcnt  <= '0;
    end else if (state == ST_HUNT) begin
      if (sfd_hit) begin
        state <= ST_LOCK;
        run   <= '0;
        hcnt  <= '0;
      end else if (hcnt == CNT_END) begin
        run  <= '0;
        hcnt <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
        if (run == '0) begin
          run  <= RUN_W'(1);
          prev <= rxd;
        end else if (rxd != prev) begin
          run  <= (run == RUN_TOP) ? RUN_TOP : run + 1'b1;
          prev <= rxd;
        end else begin
          run <= RUN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sfd_byte_asm.sv
module sfd_byte_asm #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crs,
  input  logic              rxd,
  input  logic              sfd_hit,
  input  logic              locked,
  output logic              delim_mark,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic [IDX_W-1:0]  byte_idx
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shift;
  logic [BIT_W-1:0]  bcnt;
  logic [IDX_W-1:0]  idx_next;
  logic [BYTE_W-1:0] shift_in;

  assign shift_in = {rxd, shift[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift      <= '0;
      bcnt       <= '0;
      idx_next   <= '0;
      delim_mark <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_idx   <= '0;
    end else begin
      delim_mark <= 1'b0;
      byte_valid <= 1'b0;
      if (!crs) begin
        shift    <= '0;
        bcnt     <= '0;
        idx_next <= '0;
      end else if (sfd_hit) begin
        delim_mark <= 1'b1;
        shift      <= '0;
        bcnt       <= '0;
        idx_next   <= '0;
      end else if (locked) begin
        shift <= shift_in;
        if (bcnt == BIT_END) begin
          bcnt       <= '0;
          byte_valid <= 1'b1;
          delim_mark <= 1'b1;
          byte_data  <= shift_in;
          byte_idx   <= idx_next;
          if (idx_next != '1) idx_next <= idx_next + 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfd_byte_strobe.sv
module sfd_byte_strobe #(
  parameter int MIN_ALT   = 2,
  parameter int PRE_LIMIT = 64,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 8
) (
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic              crs,
  input  logic              rxd,
  output logic              delim_mark,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              frame_active
);
  logic sfd_hit;
  logic locked;

  sfd_hunter #(.MIN_ALT(MIN_ALT), .PRE_LIMIT(PRE_LIMIT)) u_hunter (
    .clk    (rx_clk),
    .rst_n  (rst_n),
    .crs    (crs),
    .rxd    (rxd),
    .sfd_hit(sfd_hit),
    .locked (locked)
  );

  sfd_byte_asm #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_asm (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .crs       (crs),
    .rxd       (rxd),
    .sfd_hit   (sfd_hit),
    .locked    (locked),
    .delim_mark(delim_mark),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .byte_idx  (byte_idx)
  );

  assign frame_active = locked;
endmodule

// File: rtl/sfd_byte_strobe_chk.sv
module sfd_byte_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic crs,
  input logic delim_mark,
  input logic byte_valid,
  input logic frame_active
);
  p_sfd_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> delim_mark);

  p_valid_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> frame_active);

  p_valid_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> delim_mark);

  p_crs_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !crs |=> (!frame_active && !byte_valid));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
endmodule

bind sfd_byte_strobe sfd_byte_strobe_chk u_chk (
  .clk         (rx_clk),
  .rst_n       (rst_n),
  .crs         (crs),
  .delim_mark  (delim_mark),
  .byte_valid  (byte_valid),
  .frame_active(frame_active)
);

// File: tb/sfd_byte_strobe_bench.sv
module sfd_byte_strobe_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       crs = 1'b0;
  logic       rxd = 1'b0;
  logic       delim_mark, byte_valid, frame_active;
  logic [7:0] byte_data, byte_idx;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  sfd_byte_strobe #(.PRE_LIMIT(16)) u_sfd_byte_strobe (
    .rx_clk      (clk),
    .rst_n       (rst_n),
    .crs         (crs),
    .rxd         (rxd),
    .delim_mark  (delim_mark),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .byte_idx    (byte_idx),
    .frame_active(frame_active)
  );

  // each entry: {crs, rxd, expected delim_mark, expected byte_valid}
  localparam logic [3:0] VEC [16] = '{
    4'b1100, 4'b1000, 4'b1100, 4'b1000, 4'b1100, 4'b1000, 4'b1100, 4'b1110,
    4'b1100, 4'b1000, 4'b1100, 4'b1000, 4'b1000, 4'b1100, 4'b1000, 4'b1111
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic c, input logic d);
    @(negedge clk);
    crs = c;
    rxd = d;
    @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send(1'b1, b[i]);
  endtask

  task automatic send_sfd();
    for (int i = 0; i < 7; i++) send(1'b1, ~i[0]);
    send(1'b1, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 mark", int'(delim_mark), 0);
    check("R1 valid", int'(byte_valid), 0);
    check("R1 active", int'(frame_active), 0);
    check("R1 idx", int'(byte_idx), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table: delimiter then byte 0xA5
    for (int i = 0; i < 16; i++) begin
      send(VEC[i][3], VEC[i][2]);
      check("R2/R5 mark", int'(delim_mark), int'(VEC[i][1]));
      check("R4 valid", int'(byte_valid), int'(VEC[i][0]));
    end
    check("R4 lsb-first data", int'(byte_data), 8'hA5);
    check("R6 first idx", int'(byte_idx), 0);
    check("R2 active", int'(frame_active), 1);

    send_byte(8'h3C);
    check("R4 second data", int'(byte_data), 8'h3C);
    check("R6 second idx", int'(byte_idx), 1);
    check("R5 mark at byte", int'(delim_mark), 1);
    send(1'b1, 1'b0);
    check("R9 valid one cycle", int'(byte_valid), 0);

    // R7: carrier drop
    send(1'b0, 1'b0);
    check("R7 active low", int'(frame_active), 0);
    check("R7 no valid", int'(byte_valid), 0);

    // R3: early pair ignored, then delimiter after two alternating bits
    send(1'b1, 1'b0); send(1'b1, 1'b1); send(1'b1, 1'b1);
    check("R3 early pair mark", int'(delim_mark), 0);
    check("R3 early pair active", int'(frame_active), 0);
    send(1'b1, 1'b0); send(1'b1, 1'b1); send(1'b1, 1'b1);
    check("R2 detect after run", int'(delim_mark), 1);
    send(1'b1, 1'b1);
    check("R2 mark one cycle", int'(delim_mark), 0);

    // R7: partial byte discarded
    send(1'b1, 1'b1); send(1'b1, 1'b1);
    send(1'b0, 1'b0);
    send_sfd();
    send_byte(8'h5A);
    check("R7 fresh byte data", int'(byte_data), 8'h5A);
    check("R7 fresh idx", int'(byte_idx), 0);

    // R8: preamble timeout with PRE_LIMIT=16
    send(1'b0, 1'b0);
    for (int i = 0; i < 16; i++) send(1'b1, ~i[0]);
    send(1'b1, 1'b1); send(1'b1, 1'b1);
    check("R8 pair after timeout", int'(delim_mark), 0);
    check("R8 still hunting", int'(frame_active), 0);
    send(1'b1, 1'b0); send(1'b1, 1'b1); send(1'b1, 1'b1);
    check("R8 detect after rerun", int'(delim_mark), 1);

    // R6: saturation
    for (int k = 0; k < 257; k++) begin
      send_byte(k[7:0]);
      if (k >= 254) begin
        check("R6 idx saturate", int'(byte_idx), (k > 255) ? 255 : k);
        check("R4 data", int'(byte_data), k & 255);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule